// File: doc/BRIEF.md
# Training-Pattern Word Aligner

This block sits on one deserialized lane of a source-synchronous link. Each cycle it receives one raw 16-bit word and a control flag from the deserializer. Until the far end's word boundary is found, these raw words may be cut at any bit position. The block rebuilds a continuous bit stream from the current and previous raw words and cuts an aligned word from it at a bit offset it controls. The offset starts at zero. Each slip request moves it forward by exactly one bit.

The aligned words go to a training-pattern recogniser. One training pattern is a run of ten control words of value 0x0FFF followed by a run of ten data words of value 0xF000, and the pattern repeats. If no well-formed pattern shows up at the current offset within a search window, the block slips one bit, waits for the shifted data to settle, and looks again. Lock is declared after a run of consecutive good patterns. A word budget limits the whole search, and running out of it is reported as an alignment error. A lane-level clock indication that drops during training is reported the same way. A pattern whose runs have the wrong length raises a separate training error.

Top module: `lane_word_aligner`

## Requirements
- R1: After synchronous reset, `locked`, `align_err`, `tp_err` and `slip_req` are 0 and `slip_pos` is 0.
- R2: Bits arrive MSB first. `out_word` is the 16 stream bits that start `slip_pos` bits after the start of the raw word received two cycles earlier, and `out_ctl` is that earlier word's control flag. Once the lane offset is matched, the word driven in cycle n appears on `out_word` and `out_ctl` in cycle n+2.
- R3: `slip_pos` changes only in a cycle where `slip_req` is high, and then only by +1. It wraps from 15 to 0.
- R4: While no lock is being built, slip requests come exactly 52 cycles apart: 4 settle cycles, in which matching is suspended, plus a 48-cycle search window.
- R5: A well-formed pattern is exactly ten words 0x0FFF with control flag 1 followed by exactly ten words 0xF000 with control flag 0. `locked` rises after 2 consecutive well-formed patterns at one offset, and `slip_pos` then equals the lane's bit offset.
- R6: A control run or data run of a length other than ten sets `tp_err`, which stays set until reset. It clears the consecutive-good count, so alternating good and malformed patterns never lock. A run already in progress when matching resumes is not judged.
- R7: If lock has not been reached within 4400 cycles after reset (220 patterns of 20 words), `align_err` rises and slipping stops.
- R8: `lane_ok` low while training (not locked, no error yet) raises `align_err` one cycle later. Slipping then stops.
- R9: Once `locked` is high it stays high. No further slip requests are made, and `lane_ok` going low causes no error.
- R10: `locked` and `align_err` are never high together, and `align_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_word | input | 16 | Raw deserialized word, MSB received first |
| lane_ctl | input | 1 | Control flag accompanying the raw word |
| lane_ok | input | 1 | Lane clock-recovery lock indication |
| out_word | output | 16 | Aligned word at the current bit offset |
| out_ctl | output | 1 | Control flag of the aligned word |
| slip_req | output | 1 | One-cycle pulse when the offset advances by one bit |
| slip_pos | output | 4 | Current bit offset |
| locked | output | 1 | Word boundary found |
| align_err | output | 1 | Lock budget exhausted or lane lock lost in training |
| tp_err | output | 1 | Malformed training pattern seen |

## Verification
The hardest states to reach are those at the end of a long search: the offset wrapping from 15 back to 0, and the 4400-cycle budget running out. Real training data locks long before either happens. To reach them, the bench drives a pattern-free stream, so that every window expires and the offset walks through all sixteen positions and past the budget. The lane offset itself is modelled in the bench. A bit-level model delays the transmitted word stream by a chosen number of bits, so lock can be checked at offsets other than zero and the aligned output can be compared word for word against what was sent.

// File: rtl/lane_aligner_pkg.sv
package lane_aligner_pkg;

    parameter int WORD_W = 16;
    localparam int POS_W = $clog2(WORD_W);

    localparam logic [WORD_W-1:0] TP_CTL_VALUE  = 16'h0FFF;
    localparam logic [WORD_W-1:0] TP_DATA_VALUE = 16'hF000;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              ctl;
    } lane_word_t;

    typedef enum logic [1:0] {
        ST_SETTLE,
        ST_SEARCH,
        ST_LOCKED,
        ST_FAIL
    } ctrl_state_t;

    typedef enum logic [1:0] {
        PH_WAIT_GAP,
        PH_IDLE,
        PH_IN_CTL,
        PH_IN_DATA
    } match_phase_t;

    // Cut one word out of the two-word stream window, skipping k leading bits.
    function automatic logic [WORD_W-1:0] window_select(
        input logic [WORD_W-1:0] older,
        input logic [WORD_W-1:0] newer,
        input logic [POS_W-1:0]  k
    );
        logic [2*WORD_W-1:0] shifted;
        shifted = {older, newer} << k;
        return shifted[2*WORD_W-1 -: WORD_W];
    endfunction

endpackage

// File: rtl/bit_slip_shifter.sv
module bit_slip_shifter
    import lane_aligner_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] slip_pos,
    input  lane_word_t       raw_in,
    output lane_word_t       aligned_out
);
    lane_word_t prev_q;
    lane_word_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            out_q  <= '0;
        end else begin
            prev_q       <= raw_in;
            out_q.data   <= window_select(prev_q.data, raw_in.data, slip_pos);
            out_q.ctl    <= prev_q.ctl;
        end
    end

    assign aligned_out = out_q;
endmodule

// File: rtl/tp_matcher.sv
module tp_matcher
    import lane_aligner_pkg::*;
#(
    parameter int RUN_LEN = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  lane_word_t word_in,
    output logic       good,
    output logic       bad
);
    localparam int CNT_W = $clog2(RUN_LEN + 2);
    localparam logic [CNT_W-1:0] RUN_C = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(RUN_LEN + 1);

    match_phase_t     phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             good_q, bad_q;
    logic             is_ctl, is_data;

    assign is_ctl  = word_in.ctl  && (word_in.data == TP_CTL_VALUE);
    assign is_data = !word_in.ctl && (word_in.data == TP_DATA_VALUE);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= PH_WAIT_GAP;
            cnt_q   <= '0;
            good_q  <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            good_q <= 1'b0;
            bad_q  <= 1'b0;
            unique case (phase_q)
                PH_WAIT_GAP: if (!is_ctl) phase_q <= PH_IDLE;
                PH_IDLE: if (is_ctl) begin
                    phase_q <= PH_IN_CTL;
                    cnt_q   <= 1;
                end
                PH_IN_CTL: begin
                    if (is_ctl) begin
                        if (cnt_q != SAT_C) cnt_q <= cnt_q + 1'b1;
                    end else if (is_data && cnt_q == RUN_C) begin
                        phase_q <= PH_IN_DATA;
                        cnt_q   <= 1;
                    end else begin
                        bad_q   <= 1'b1;
                        phase_q <= PH_IDLE;
                    end
                end
                PH_IN_DATA: begin
                    if (is_data) begin
                        if (cnt_q != SAT_C) cnt_q <= cnt_q + 1'b1;
                    end else begin
                        if (cnt_q == RUN_C) good_q <= 1'b1;
                        else                bad_q  <= 1'b1;
                        if (is_ctl) begin
                            phase_q <= PH_IN_CTL;
                            cnt_q   <= 1;
                        end else begin
                            phase_q <= PH_IDLE;
                        end
                    end
                end
                default: phase_q <= PH_WAIT_GAP;
            endcase
        end
    end

    assign good = good_q;
    assign bad  = bad_q;

    // R6
    good_bad_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(good_q && bad_q));
endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
    import lane_aligner_pkg::*;
#(
    parameter int GOOD_NEED    = 2,
    parameter int SETTLE_WORDS = 4,
    parameter int SEARCH_WORDS = 48,
    parameter int BUDGET_WORDS = 4400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lane_ok,
    input  logic             good,
    input  logic             bad,
    output logic             match_clr,
    output logic             slip_req,
    output logic [POS_W-1:0] slip_pos,
    output logic             locked,
    output logic             align_err,
    output logic             tp_err
);
    localparam int TMR_W = $clog2(SETTLE_WORDS + SEARCH_WORDS + 1);
    localparam int GC_W  = $clog2(GOOD_NEED + 1);
    localparam int BUD_W = $clog2(BUDGET_WORDS + 1);

    ctrl_state_t      state_q;
    logic [TMR_W-1:0] tmr_q;
    logic [GC_W-1:0]  gcnt_q;
    logic [BUD_W-1:0] bud_q;
    logic [POS_W-1:0] pos_q;
    logic             slip_q, tp_q;
    logic             training, g_in, b_in;

    assign training = (state_q == ST_SETTLE) || (state_q == ST_SEARCH);
    assign g_in     = (state_q == ST_SEARCH) && good;
    assign b_in     = (state_q == ST_SEARCH) && bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SETTLE;
            tmr_q   <= '0;
            gcnt_q  <= '0;
            bud_q   <= '0;
            pos_q   <= '0;
            slip_q  <= 1'b0;
            tp_q    <= 1'b0;
        end else begin
            slip_q <= 1'b0;
            if (training && bud_q != BUD_W'(BUDGET_WORDS)) bud_q <= bud_q + 1'b1;
            if (b_in) tp_q <= 1'b1;

            if (training && !lane_ok) begin
                state_q <= ST_FAIL;
            end else if (g_in && gcnt_q == GC_W'(GOOD_NEED - 1)) begin
                state_q <= ST_LOCKED;
            end else if (training && bud_q == BUD_W'(BUDGET_WORDS - 1)) begin
                state_q <= ST_FAIL;
            end else if (state_q == ST_SETTLE) begin
                if (tmr_q == TMR_W'(SETTLE_WORDS - 1)) begin
                    state_q <= ST_SEARCH;
                    tmr_q   <= '0;
                end else begin
                    tmr_q <= tmr_q + 1'b1;
                end
            end else if (state_q == ST_SEARCH) begin
                if (g_in) begin
                    gcnt_q <= gcnt_q + 1'b1;
                    tmr_q  <= '0;
                end else begin
                    if (b_in) gcnt_q <= '0;
                    if (tmr_q == TMR_W'(SEARCH_WORDS - 1)) begin
                        state_q <= ST_SETTLE;
                        tmr_q   <= '0;
                        gcnt_q  <= '0;
                        slip_q  <= 1'b1;
                        pos_q   <= (pos_q == POS_W'(WORD_W - 1)) ? '0 : pos_q + 1'b1;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
            end
        end
    end

    assign match_clr = (state_q != ST_SEARCH);
    assign slip_req  = slip_q;
    assign slip_pos  = pos_q;
    assign locked    = (state_q == ST_LOCKED);
    assign align_err = (state_q == ST_FAIL);
    assign tp_err    = tp_q;

    // R3
    slip_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q != $past(pos_q)) |-> (slip_q && pos_q == POS_W'($past(pos_q) + 1'b1)));
    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && !slip_q));
    // R8
    lane_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && !align_err && !lane_ok) |=> align_err);
    // R10
    lock_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(locked && align_err));
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        align_err |=> align_err);
    // R6
    tp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        tp_q |=> tp_q);
    // R7
    budget_chk: assert property (@(posedge clk) disable iff (rst)
        (bud_q == BUD_W'(BUDGET_WORDS)) |-> !slip_q);
endmodule

// File: rtl/lane_word_aligner.sv
module lane_word_aligner
    import lane_aligner_pkg::*;
#(
    parameter int RUN_LEN         = 10,
    parameter int GOOD_NEED       = 2,
    parameter int SETTLE_WORDS    = 4,
    parameter int SEARCH_WORDS    = 48,
    parameter int BUDGET_PATTERNS = 220
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] lane_word,
    input  logic              lane_ctl,
    input  logic              lane_ok,
    output logic [WORD_W-1:0] out_word,
    output logic              out_ctl,
    output logic              slip_req,
    output logic [POS_W-1:0]  slip_pos,
    output logic              locked,
    output logic              align_err,
    output logic              tp_err
);
    localparam int PATTERN_WORDS = 2 * RUN_LEN;
    localparam int BUDGET_WORDS  = BUDGET_PATTERNS * PATTERN_WORDS;

    lane_word_t raw_w, aligned_w;
    logic       clr_w, good_w, bad_w;

    assign raw_w.data = lane_word;
    assign raw_w.ctl  = lane_ctl;

    bit_slip_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .slip_pos    (slip_pos),
        .raw_in      (raw_w),
        .aligned_out (aligned_w)
    );

    tp_matcher #(.RUN_LEN(RUN_LEN)) u_match (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_w),
        .word_in (aligned_w),
        .good    (good_w),
        .bad     (bad_w)
    );

    align_ctrl #(
        .GOOD_NEED    (GOOD_NEED),
        .SETTLE_WORDS (SETTLE_WORDS),
        .SEARCH_WORDS (SEARCH_WORDS),
        .BUDGET_WORDS (BUDGET_WORDS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .lane_ok   (lane_ok),
        .good      (good_w),
        .bad       (bad_w),
        .match_clr (clr_w),
        .slip_req  (slip_req),
        .slip_pos  (slip_pos),
        .locked    (locked),
        .align_err (align_err),
        .tp_err    (tp_err)
    );

    assign out_word = aligned_w.data;
    assign out_ctl  = aligned_w.ctl;
endmodule

// File: tb/lane_word_aligner_bench.sv
module lane_word_aligner_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lane_word = '0;
    logic        lane_ctl = 1'b0;
    logic        lane_ok = 1'b1;
    logic [15:0] out_word;
    logic        out_ctl;
    logic        slip_req;
    logic [3:0]  slip_pos;
    logic        locked, align_err, tp_err;

    int checks = 0;
    int errors = 0;
    int offset_m = 0;
    int slips_seen = 0;
    logic [15:0] prev_t = '0;

    always #2 clk = ~clk;

    lane_word_aligner u_lane_word_aligner (
        .clk(clk), .rst(rst), .lane_word(lane_word), .lane_ctl(lane_ctl),
        .lane_ok(lane_ok), .out_word(out_word), .out_ctl(out_ctl),
        .slip_req(slip_req), .slip_pos(slip_pos), .locked(locked),
        .align_err(align_err), .tp_err(tp_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one transmitted word through a lane delayed by offset_m bits.
    task automatic put_word(input logic [15:0] t, input logic c);
        logic [31:0] cat;
        @(negedge clk);
        if (slip_req) slips_seen++;
        cat = {prev_t, t};
        lane_word = 16'(cat >> offset_m);
        lane_ctl  = c;
        prev_t    = t;
    endtask

    task automatic send_pattern(input int ctl_len, input int data_len);
        for (int i = 0; i < ctl_len; i++)  put_word(16'h0FFF, 1'b1);
        for (int i = 0; i < data_len; i++) put_word(16'hF000, 1'b0);
    endtask

    task automatic do_reset(input int m);
        rst = 1'b1; lane_ok = 1'b1; offset_m = m; prev_t = '0;
        lane_word = '0; lane_ctl = 1'b0; slips_seen = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(0);
        chk(!locked, "R1 locked", int'(locked), 0);
        chk(!align_err, "R1 align_err", int'(align_err), 0);
        chk(!tp_err, "R1 tp_err", int'(tp_err), 0);
        chk(slip_pos == 0, "R1 slip_pos", int'(slip_pos), 0);
        chk(!slip_req, "R1 slip_req", int'(slip_req), 0);
    endtask

    task automatic t_lock(input int m);
        logic [15:0] hist [0:11];
        logic        hctl [0:11];
        int          pos_at_lock, slips_at_lock;
        do_reset(m);
        for (int p = 0; p < 80 && !locked; p++) send_pattern(10, 10);
        chk(locked, "R5 locked", int'(locked), 1);
        chk(slip_pos == 4'(m), "R5 slip_pos", int'(slip_pos), m);
        chk(slips_seen == m, "R3 slip count", slips_seen, m);
        chk(!tp_err && !align_err, "R5 no errors", int'({tp_err, align_err}), 0);
        // R2: aligned word stream equals transmitted stream delayed by two cycles
        for (int i = 0; i < 12; i++) begin
            hist[i] = 16'h1357 + 16'(i) * 16'h0203;
            hctl[i] = i[0];
            put_word(hist[i], hctl[i]);
            if (i >= 2)
                chk(out_word == hist[i-2] && out_ctl == hctl[i-2], "R2 out_word",
                    int'(out_word), int'(hist[i-2]));
        end
        pos_at_lock = int'(slip_pos);
        slips_at_lock = slips_seen;
        for (int i = 0; i < 200; i++) put_word(16'h0000, 1'b0);
        chk(locked && slips_seen == slips_at_lock, "R9 no slip after lock",
            slips_seen, slips_at_lock);
        chk(int'(slip_pos) == pos_at_lock, "R9 slip_pos held", int'(slip_pos), pos_at_lock);
        lane_ok = 1'b0;
        for (int i = 0; i < 10; i++) put_word(16'h0000, 1'b0);
        chk(!align_err && locked, "R9 lane_ok drop after lock", int'(align_err), 0);
        lane_ok = 1'b1;
    endtask

    task automatic t_wrap();
        int last, since, seen;
        do_reset(0);
        last = 0; since = 0; seen = 0;
        for (int i = 0; i < 1000 && seen < 17; i++) begin
            put_word(16'h0000, 1'b0);
            since++;
            if (slip_req) begin
                chk(int'(slip_pos) == (last + 1) % 16, "R3 slip step",
                    int'(slip_pos), (last + 1) % 16);
                if (seen > 0) chk(since == 52, "R4 slip interval", since, 52);
                last = int'(slip_pos);
                since = 0;
                seen++;
                if (seen == 16) chk(slip_pos == 0, "R3 wrap to 0", int'(slip_pos), 0);
            end
        end
        chk(seen == 17, "R3 slips observed", seen, 17);
    endtask

    task automatic t_malformed();
        do_reset(3);
        for (int p = 0; p < 60; p++) send_pattern(10, 9);
        chk(tp_err, "R6 short data run", int'(tp_err), 1);
        chk(!locked, "R6 no lock on malformed", int'(locked), 0);
    endtask

    task automatic t_alternating();
        do_reset(0);
        for (int p = 0; p < 30; p++) begin
            send_pattern(10, 10);
            send_pattern(11, 10);
        end
        chk(tp_err, "R6 long control run", int'(tp_err), 1);
        chk(!locked, "R6 alternating never locks", int'(locked), 0);
    endtask

    task automatic t_budget();
        int pos_hold;
        do_reset(0);
        for (int i = 0; i < 4300; i++) put_word(16'h0000, 1'b0);
        chk(!align_err, "R7 before budget", int'(align_err), 0);
        for (int i = 0; i < 150; i++) put_word(16'h0000, 1'b0);
        chk(align_err && !locked, "R7 budget expired", int'(align_err), 1);
        pos_hold = int'(slip_pos);
        for (int i = 0; i < 120; i++) put_word(16'h0000, 1'b0);
        chk(int'(slip_pos) == pos_hold, "R7 slipping stopped", int'(slip_pos), pos_hold);
    endtask

    task automatic t_lane_drop();
        int pos_hold;
        do_reset(0);
        for (int i = 0; i < 100; i++) put_word(16'h0000, 1'b0);
        chk(!align_err, "R8 before drop", int'(align_err), 0);
        lane_ok = 1'b0;
        put_word(16'h0000, 1'b0);
        put_word(16'h0000, 1'b0);
        chk(align_err, "R8 align_err after drop", int'(align_err), 1);
        lane_ok = 1'b1;
        pos_hold = int'(slip_pos);
        for (int i = 0; i < 200; i++) put_word(16'h0000, 1'b0);
        chk(int'(slip_pos) == pos_hold && align_err && !locked, "R10 error held",
            int'(slip_pos), pos_hold);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset_state();
        t_lock(0);
        t_lock(11);
        t_wrap();
        t_malformed();
        t_alternating();
        t_budget();
        t_lane_drop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule